// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous valid/ready write port and a 128K x 8 asynchronous static RAM. Each accepted request is turned into one framed write. The address and data are presented first, with both strobes high. Chip-enable then falls, and write-enable falls one cycle later. Write-enable rises first, which ends the write, and chip-enable rises one cycle after that. The memory's output-enable stays high throughout, and the data bus is modelled as a separate value and drive-enable.

Every interval is a whole number of clock cycles. It is computed at elaboration from the chosen speed grade (70, 85 or 120 ns sets) and the clock period in picoseconds, as the rounded-up quotient with a floor of one cycle. The low time of write-enable is stretched so that it covers four minimums together: pulse width, chip-enable-to-end, address-to-end and data-to-end. A short recovery phase is added where one is needed, so that two acceptances are never closer than the total write cycle time.

Top module: `sram_wr_ctrl`

## Requirements
- R1: After reset, req_ready is 1, mem_ce_n and mem_we_n are 1, mem_oe_n is 1 and mem_dout_en is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle on, req_ready is 0 and mem_addr/mem_dout carry the accepted address and data.
- R3: In the first cycle after acceptance both strobes are high. mem_ce_n falls in the second cycle and mem_we_n falls in the third. mem_we_n is never low while mem_ce_n is high.
- R4: mem_we_n stays low for exactly P cycles. With c(t) = max(1, ceil(t/Tclk)), P = max(c(tWP), c(tCW)-1, c(tAW)-2, c(tDW)-2). For the 120 ns grade at 5 ns this gives P = 19.
- R5: mem_we_n rises exactly one cycle before mem_ce_n rises, so mem_ce_n is low for P+2 cycles.
- R6: mem_addr and mem_dout change only at an acceptance, and only when both mem_ce_n and mem_we_n are high.
- R7: mem_oe_n is always 1. mem_dout_en is 1 for P+3 cycles starting in the cycle after acceptance, and is 0 again when req_ready returns.
- R8: After an acceptance, req_ready stays 0 for B = max(P+3, c(tWC)-1) cycles. For 120 ns at 5 ns this is 23.
- R9: If req_valid is held high, the next request is accepted on the first edge where req_ready is 1. Accept-to-accept spacing is then B+1 cycles, which is never less than c(tWC).
- R10: While req_valid is 0 and the block is idle, the strobes stay high, mem_dout_en stays 0 and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dout | output | DATA_W | Data driven onto the memory bus |
| mem_dout_en | output | 1 | Controller drives the data bus |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, held high |

## Verification
Every output is registered, so each result appears one cycle after the edge that decides it. Address, data, drive-enable and ready change in the cycle after acceptance. Chip-enable falls in the second cycle and write-enable in the third. Ready returns in cycle B+1 after acceptance. The bench drives inputs and samples outputs on falling edges. It counts sampled cycles from the acceptance edge: the low cycles of each strobe, the drive-enable cycles and the busy cycles. It compares these counts with P and B, which it computes from the nanosecond table and the clock period rather than from the design.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
// sram_wr_pkg: shared state type and elaboration-time timing arithmetic.
// Assumes nanosecond minimums per speed grade and a clock period in ps.
package sram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_LEAD, ST_PULSE, ST_HOLD, ST_REC
    } wr_state_e;

    localparam int T_CYCLE = 0;  // total write cycle
    localparam int T_PULSE = 1;  // write-enable low width
    localparam int T_ADDR  = 2;  // address (and chip-enable) to end of write
    localparam int T_DATA  = 3;  // data valid to end of write

    // Minimum in ns for a grade; unknown grades use the fastest set.
    function automatic int grade_ns(input int grade, input int kind);
        int v;
        case (grade)
            85: case (kind)
                    T_CYCLE: v = 85;  T_PULSE: v = 65;
                    T_ADDR:  v = 75;  default: v = 35;
                endcase
            120: case (kind)
                    T_CYCLE: v = 120; T_PULSE: v = 85;
                    T_ADDR:  v = 100; default: v = 45;
                endcase
            default: case (kind)
                    T_CYCLE: v = 70;  T_PULSE: v = 55;
                    T_ADDR:  v = 65;  default: v = 30;
                endcase
        endcase
        return v;
    endfunction

    // Round a ns minimum up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Write-enable low cycles covering all end-of-write minimums.
    function automatic int pulse_cyc(input int grade, input int clk_ps);
        int p;
        p = ns_to_cyc(grade_ns(grade, T_PULSE), clk_ps);
        if (ns_to_cyc(grade_ns(grade, T_ADDR), clk_ps) - 1 > p)
            p = ns_to_cyc(grade_ns(grade, T_ADDR), clk_ps) - 1;
        if (ns_to_cyc(grade_ns(grade, T_DATA), clk_ps) - 2 > p)
            p = ns_to_cyc(grade_ns(grade, T_DATA), clk_ps) - 2;
        return p;
    endfunction

    // Extra strobe-high cycles so accept-to-accept meets the cycle time.
    function automatic int rec_cyc(input int grade, input int clk_ps);
        int r;
        r = ns_to_cyc(grade_ns(grade, T_CYCLE), clk_ps) - 4 - pulse_cyc(grade, clk_ps);
        return (r < 0) ? 0 : r;
    endfunction

endpackage

// File: rtl/sram_wr_cnt.sv
`timescale 1ns/1ps
// sram_wr_cnt: loadable down-counter used to time the long write phases.
// Assumes load and count never need to happen in the same cycle.
module sram_wr_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new span or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_wr_fsm.sv
`timescale 1ns/1ps
// sram_wr_fsm: sequences setup, chip-enable lead, write pulse, hold and
// recovery phases. The strobes are registered from the next state, so they
// change cleanly one cycle after each decision. Assumes PULSE_CYC >= 1.
module sram_wr_fsm
    import sram_wr_pkg::*;
#(
    parameter int PULSE_CYC = 19,
    parameter int REC_CYC   = 1,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             capture,
    output logic             ce_n,
    output logic             we_n,
    output logic             dout_en,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_zero
);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD   = CNT_W'((REC_CYC > 0) ? REC_CYC - 1 : 0);

    wr_state_e state_q, state_d;

    assign req_ready = (state_q == ST_IDLE);
    assign capture   = req_valid && req_ready;

    // Next-state and counter-load decisions.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = PULSE_LD;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_LEAD;
            ST_LEAD: begin
                state_d  = ST_PULSE;
                cnt_load = 1'b1;
            end
            ST_PULSE: if (cnt_zero) state_d = ST_HOLD;
            ST_HOLD: begin
                if (REC_CYC > 0) begin
                    state_d  = ST_REC;
                    cnt_load = 1'b1;
                    cnt_val  = REC_LD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_REC:   if (cnt_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register plus strobe registers decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
            dout_en <= 1'b0;
        end else begin
            state_q <= state_d;
            ce_n    <= !(state_d == ST_LEAD || state_d == ST_PULSE || state_d == ST_HOLD);
            we_n    <= !(state_d == ST_PULSE);
            dout_en <= (state_d == ST_SETUP || state_d == ST_LEAD ||
                        state_d == ST_PULSE || state_d == ST_HOLD);
        end
    end
endmodule

// File: rtl/sram_wr_dp.sv
`timescale 1ns/1ps
// sram_wr_dp: holds the accepted address and data on the memory pins.
// Assumes capture occurs only while both strobes are high (idle state).
module sram_wr_dp #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    // Register the request on acceptance; hold until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_data <= '0;
        end else if (capture) begin
            out_addr <= in_addr;
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/sram_wr_ctrl.sv
`timescale 1ns/1ps
// sram_wr_ctrl: top of the asynchronous SRAM write sequencer. It derives
// the cycle counts from GRADE (70/85/120 ns sets) and CLK_PS, then wires
// the phase FSM, phase counter and address/data holding registers.
// Assumes a write-enable-terminated cycle and no reads.
module sram_wr_ctrl
    import sram_wr_pkg::*;
#(
    parameter int GRADE  = 70,
    parameter int CLK_PS = 5000,
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    localparam int PULSE_CYC = pulse_cyc(GRADE, CLK_PS);
    localparam int REC_CYC   = rec_cyc(GRADE, CLK_PS);
    localparam int CNT_W     = $clog2(PULSE_CYC + REC_CYC + 1) + 1;

    logic             capture;
    logic             cnt_load;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    sram_wr_fsm #(
        .PULSE_CYC(PULSE_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .capture(capture), .ce_n(mem_ce_n), .we_n(mem_we_n),
        .dout_en(mem_dout_en), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .cnt_zero(cnt_zero)
    );

    sram_wr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .zero(cnt_zero)
    );

    sram_wr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .capture(capture), .in_addr(req_addr),
        .in_data(req_data), .out_addr(mem_addr), .out_data(mem_dout)
    );

    // The memory never drives the bus during writes.
    assign mem_oe_n = 1'b1;
endmodule

// File: rtl/sram_wr_chk.sv
`timescale 1ns/1ps
// sram_wr_chk: protocol assertions for sram_wr_ctrl, attached by bind.
// Assumes the same GRADE/CLK_PS as the bound instance.
module sram_wr_chk
    import sram_wr_pkg::*;
#(
    parameter int GRADE  = 70,
    parameter int CLK_PS = 5000,
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dout_en,
    input logic              mem_ce_n,
    input logic              mem_we_n
);
    localparam int WP_MIN = ns_to_cyc(grade_ns(GRADE, T_PULSE), CLK_PS);

    int wlow_q;

    // Count consecutive cycles with write-enable low.
    always_ff @(posedge clk) begin
        if (!rst_n)        wlow_q <= 0;
        else if (!mem_we_n) wlow_q <= wlow_q + 1;
        else               wlow_q <= 0;
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dout_en));

    assert_ce_leads_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(!mem_ce_n));

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wlow_q >= WP_MIN));

    assert_we_ends_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> $past(mem_we_n));

    assert_addr_strobes_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_ce_n && mem_we_n && $past(mem_ce_n)));
endmodule

bind sram_wr_ctrl sram_wr_chk #(
    .GRADE(GRADE), .CLK_PS(CLK_PS), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_dout_en(mem_dout_en), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n)
);

// File: tb/sram_wr_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for sram_wr_ctrl at the 120 ns grade with a 5 ns clock.
module sram_wr_ctrl_bench;
    localparam int GRADE = 120;
    localparam int CLK_PS = 5000;

    // Expected counts from the requirement formulas and the 120 ns set.
    function automatic int cy(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int EXP_P    = mx(mx(cy(85), cy(100) - 1), mx(cy(100) - 2, cy(45) - 2));
    localparam int EXP_BUSY = mx(EXP_P + 3, cy(120) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        req_ready;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dout;
    logic        mem_dout_en, mem_ce_n, mem_we_n, mem_oe_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram_wr_ctrl #(.GRADE(GRADE), .CLK_PS(CLK_PS)) u_sram_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: reset values.
    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(mem_ce_n && mem_we_n, "R1 strobes", {mem_ce_n, mem_we_n}, 3);
        chk(mem_oe_n == 1'b1, "R1 oe_n", mem_oe_n, 1);
        chk(mem_dout_en == 1'b0, "R1 dout_en", mem_dout_en, 0);
    endtask

    // One isolated write: R2, R3, R4, R5, R6, R7, R8.
    task automatic t_single(input logic [16:0] a, input logic [7:0] d);
        int welow = 0, celow = 1, drv = 2, busy = 2, oebad = 0, addrbad = 0;
        bit we_first = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_data = ~d;
        chk(!req_ready, "R2 ready low", req_ready, 0);
        chk(mem_addr == a, "R2 addr", int'(mem_addr), int'(a));
        chk(mem_dout == d, "R2 data", int'(mem_dout), int'(d));
        chk(mem_ce_n && mem_we_n, "R3 setup strobes", {mem_ce_n, mem_we_n}, 3);
        chk(mem_dout_en, "R7 drive in setup", mem_dout_en, 1);
        @(negedge clk);
        chk(!mem_ce_n && mem_we_n, "R3 ce lead", {mem_ce_n, mem_we_n}, 1);
        @(negedge clk);
        chk(!mem_we_n, "R3 we falls third cycle", mem_we_n, 0);
        while (!req_ready) begin
            if (!mem_we_n) welow++;
            if (!mem_ce_n) celow++;
            if (mem_dout_en) drv++;
            if (mem_we_n && !mem_ce_n && welow > 0) we_first = 1'b1;
            if (!mem_oe_n) oebad++;
            if (mem_addr != a || mem_dout != d) addrbad++;
            busy++;
            @(negedge clk);
        end
        chk(welow == EXP_P, "R4 we low width", welow, EXP_P);
        chk(we_first, "R5 we rises before ce", we_first, 1);
        chk(celow == EXP_P + 2, "R5 ce low width", celow, EXP_P + 2);
        chk(drv == EXP_P + 3, "R7 drive cycles", drv, EXP_P + 3);
        chk(oebad == 0, "R7 oe_n high", oebad, 0);
        chk(addrbad == 0, "R6 addr/data held", addrbad, 0);
        chk(busy == EXP_BUSY, "R8 busy cycles", busy, EXP_BUSY);
        chk(mem_ce_n && mem_we_n && !mem_dout_en, "R8 idle outputs",
            {mem_ce_n, mem_we_n, mem_dout_en}, 6);
    endtask

    // R9 and R6: back-to-back requests with valid held high.
    task automatic t_back2back(input logic [16:0] a, input logic [16:0] b);
        int busy = 0, addrbad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = 8'h3C;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_addr = b; req_data = 8'hC3;
        while (!req_ready) begin
            if (mem_addr != a) addrbad++;
            busy++;
            @(negedge clk);
        end
        chk(addrbad == 0, "R6 addr held until next accept", addrbad, 0);
        chk(busy + 1 == EXP_BUSY + 1, "R9 accept spacing", busy + 1, EXP_BUSY + 1);
        chk(busy + 1 >= cy(120), "R9 spacing covers cycle time", busy + 1, cy(120));
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_addr == b && !req_ready, "R9 second accepted at once", int'(mem_addr), int'(b));
        chk(mem_ce_n && mem_we_n, "R6 strobes high at addr change", {mem_ce_n, mem_we_n}, 3);
        while (!req_ready) @(negedge clk);
    endtask

    // R10: idle without requests.
    task automatic t_idle();
        int bad = 0;
        req_valid = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!req_ready || !mem_ce_n || !mem_we_n || mem_dout_en) bad++;
        end
        chk(bad == 0, "R10 idle quiet", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_single(17'h0A5C3, 8'h5A);
        t_single(17'h1FFFF, 8'hFF);
        t_single(17'h00000, 8'h00);
        t_back2back(17'h12345, 17'h0ABCD);
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule